// File: doc/BRIEF.md
# Row-Wrapping I2C Target for a Byte Array

This block sits on a two-wire I2C bus as a target and gives a controller access to a 256-entry byte array. The array itself lives outside the block and is reached through a plain synchronous port: an address, write data, a one-cycle write strobe and read data. The read data must follow the address combinationally or within a few cycles.

The block samples SCL and SDA through two-flop synchronisers and detects bus edges in the system clock domain. It never drives the bus high. It only asserts a pull-low enable on SDA.

A transaction begins with an address byte. The block answers when the upper four bits are 1010 and the lower three bits match its three select pins. In a write, the next byte loads the internal address pointer and every byte after that is stored. The pointer's low three bits advance and wrap inside the current 8-byte row, so a burst never leaves its row. In a read, bytes are returned from the pointer, and the pointer steps across the whole 8-bit range.

Top module: `i2c_row_target`

## Requirements
- R1: The block acknowledges an address byte whose bits 7:1 equal 1010 followed by the select pins (pin 2 down to pin 0). Acknowledging means pulling SDA low during the 9th SCL clock of that byte.
- R2: If bits 7:1 of the address byte do not match, the block leaves SDA released and issues no write strobe for the rest of the transaction. This holds until the next START.
- R3: In a write transaction (bit 0 of the address byte is 0), the second byte is taken as the new pointer value and is acknowledged.
- R4: Each further byte of a write is received MSB first and acknowledged. It produces exactly one single-cycle write strobe carrying that byte and the current pointer.
- R5: After each stored byte, bits 2:0 of the pointer increment modulo 8 and bits 7:3 stay unchanged. Starting at 06h with data 11h, 22h, 33h stores them at 06h, 07h and 00h.
- R6: In a read transaction (bit 0 of the address byte is 1), bytes are sent MSB first. SDA changes only after SCL falls and stays steady while SCL is high. SDA is released during the controller's acknowledge clock.
- R7: After each byte sent, the pointer increments over the full 8-bit range, so FFh is followed by 00h. An ACK (SDA low in the 9th clock) from the controller starts the next byte. A NACK (SDA high) leaves SDA released until a new START.
- R8: A read that is not preceded by a pointer write starts at the pointer left by the previous transaction.
- R9: A START (SDA falls while SCL is high) or a STOP (SDA rises while SCL is high) restarts the protocol from any point. A byte cut short by a STOP is never stored, and a repeated START is handled like a first START.
- R10: After reset, and whenever no acknowledge or read-data slot is active, the pull-low enable is 0 and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| sda_pull_o | output | 1 | When 1, the pad pulls SDA low |
| addr_sel_i | input | 3 | Select pins forming the low three address bits |
| mem_addr_o | output | 8 | Array address (the current pointer) |
| mem_wdata_o | output | 8 | Byte to be stored |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_rdata_i | input | 8 | Array contents at mem_addr_o |

## Verification
A wrong pointer appears on the address port at the first write strobe after the fault. In a read, it appears as a wrong byte within the next nine SCL clocks. A bit counter that has slipped moves the acknowledge into the wrong SCL slot, and the controller sees this on SDA within one byte. A protocol state stuck in the ignore mode, or one that wrongly leaves it, shows up at the next address byte. There the acknowledge is either missing or present when it should not be, and the reference model flags any unexpected strobe or pull-low on the clock where it occurs.

// File: rtl/i2c_row_target.sv
module i2c_row_target #(
  parameter logic [3:0] DEV_PREFIX = 4'b1010,
  parameter int ROW_BITS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [2:0] addr_sel_i,
  output logic [7:0] mem_addr_o,
  output logic [7:0] mem_wdata_o,
  output logic       mem_we_o,
  input  logic [7:0] mem_rdata_i
);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_MADDR, S_WDATA, S_RDATA, S_SKIP} state_t;

  logic [2:0] scl_q, sda_q;
  state_t     state;
  logic [3:0] cnt;
  logic [7:0] sr, ptr;
  logic       rd, ack_m, pull, we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  wire stop_c   = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
  wire bit_in   = sda_q[1];

  assign sda_pull_o  = pull;
  assign mem_addr_o  = ptr;
  assign mem_wdata_o = sr;
  assign mem_we_o    = we;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      sr    <= '0;
      ptr   <= '0;
      rd    <= 1'b0;
      ack_m <= 1'b0;
      pull  <= 1'b0;
      we    <= 1'b0;
    end else begin
      we <= 1'b0;
      if (start_c) begin
        state <= S_DEV;
        cnt   <= '0;
        pull  <= 1'b0;
      end else if (stop_c) begin
        state <= S_IDLE;
        cnt   <= '0;
        pull  <= 1'b0;
      end else begin
        case (state)
          S_DEV, S_MADDR, S_WDATA: begin
            if (scl_rise && cnt < 4'd8) begin
              sr  <= {sr[6:0], bit_in};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= 4'd9;
              case (state)
                S_DEV:
                  if (sr[7:1] == {DEV_PREFIX, addr_sel_i}) begin
                    pull <= 1'b1;
                    rd   <= sr[0];
                  end else begin
                    state <= S_SKIP;
                  end
                S_MADDR: begin
                  ptr  <= sr;
                  pull <= 1'b1;
                end
                default: begin
                  we   <= 1'b1;
                  pull <= 1'b1;
                end
              endcase
            end else if (scl_fall && cnt == 4'd9) begin
              pull <= 1'b0;
              cnt  <= '0;
              case (state)
                S_DEV:
                  if (rd) begin
                    state <= S_RDATA;
                    sr    <= mem_rdata_i;
                    pull  <= ~mem_rdata_i[7];
                  end else begin
                    state <= S_MADDR;
                  end
                S_MADDR: state <= S_WDATA;
                default: ptr <= {ptr[7:ROW_BITS], ptr[ROW_BITS-1:0] + 1'b1};
              endcase
            end
          end
          S_RDATA: begin
            if (scl_rise && cnt < 4'd8) begin
              cnt <= cnt + 4'd1;
            end else if (scl_rise && cnt == 4'd8) begin
              cnt   <= 4'd9;
              ack_m <= ~bit_in;
              ptr   <= ptr + 8'd1;
            end else if (scl_fall && cnt >= 4'd1 && cnt <= 4'd7) begin
              sr   <= {sr[6:0], 1'b0};
              pull <= ~sr[6];
            end else if (scl_fall && cnt == 4'd8) begin
              pull <= 1'b0;
            end else if (scl_fall && cnt == 4'd9) begin
              cnt <= '0;
              if (ack_m) begin
                sr   <= mem_rdata_i;
                pull <= ~mem_rdata_i[7];
              end else begin
                state <= S_SKIP;
              end
            end
          end
          default: ;
        endcase
      end
    end

  AST_QUIET_WHEN_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE || state == S_SKIP) |-> !sda_pull_o); // R2
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |=> !mem_we_o); // R4
  AST_ROW_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WDATA && $past(state) == S_WDATA) |-> ptr[7:ROW_BITS] == $past(ptr[7:ROW_BITS])); // R5
  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q[1] && scl_q[2] && !start_c && !stop_c) |=> $stable(sda_pull_o)); // R6
  AST_STROBE_NEEDS_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> !scl_q[2]); // R10

endmodule

// File: tb/tb_i2c_row_target.sv
module tb_i2c_row_target;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, scl_m, sda_m;
  logic [2:0] pins;
  logic       sda_pull, mem_we;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  wire        sda_line = sda_m & ~sda_pull;

  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int         ref_ptr;
  logic [7:0] exp_a[$];
  logic [7:0] exp_d[$];
  bit         quiet;
  int         checks, fails;
  bit         done;

  assign mem_rdata = mem[mem_addr];
  always_ff @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  i2c_row_target dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .addr_sel_i(pins), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_we_o(mem_we), .mem_rdata_i(mem_rdata));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    if (mem_we) begin
      if (exp_a.size() == 0) chk(0, "R2/R9 unexpected strobe", int'(mem_addr), -1);
      else begin
        chk(mem_addr == exp_a[0], "R5 strobe address", int'(mem_addr), int'(exp_a[0]));
        chk(mem_wdata == exp_d[0], "R4 strobe data", int'(mem_wdata), int'(exp_d[0]));
        void'(exp_a.pop_front());
        void'(exp_d.pop_front());
      end
    end
    if (quiet) chk(!sda_pull, "R2 pull while unaddressed", int'(sda_pull), 0);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(3);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b0; tick(4);
    scl_m = 1'b0; tick(3);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(3);
    scl_m = 1'b1; tick(4);
    sda_m = 1'b1; tick(6);
  endtask

  task automatic bit_w(input logic b);
    sda_m = b; tick(4);
    scl_m = 1'b1; tick(6);
    scl_m = 1'b0; tick(4);
  endtask

  task automatic bit_r(output logic b, input string req);
    logic s1;
    sda_m = 1'b1; tick(4);
    scl_m = 1'b1; tick(2);
    s1 = sda_line; tick(4);
    b = sda_line;
    chk(s1 == b, req, int'(b), int'(s1));
    scl_m = 1'b0; tick(4);
  endtask

  task automatic wbyte(input logic [7:0] v, input logic exp_ack, input string req);
    logic a;
    for (int i = 7; i >= 0; i--) bit_w(v[i]);
    bit_r(a, "R6 ack slot steady");
    chk(a == exp_ack, req, int'(a), int'(exp_ack));
  endtask

  task automatic rbyte(input logic nack, input string req);
    logic [7:0] v;
    logic b;
    logic [7:0] e;
    e = ref_mem[ref_ptr];
    ref_ptr = (ref_ptr + 1) & 255;
    for (int i = 7; i >= 0; i--) begin
      bit_r(b, "R6 data steady while SCL high");
      v[i] = b;
    end
    chk(v == e, req, int'(v), int'(e));
    bit_w(nack);
  endtask

  function automatic logic [7:0] dev(input logic [2:0] p, input logic rw);
    return {4'b1010, p, rw};
  endfunction

  task automatic wr_txn(input logic [7:0] ma, input int n, input logic [7:0] base, input logic [7:0] step);
    logic [7:0] d;
    bus_start();
    wbyte(dev(pins, 1'b0), 1'b0, "R1 address ack");
    wbyte(ma, 1'b0, "R3 pointer byte ack");
    ref_ptr = ma;
    for (int i = 0; i < n; i++) begin
      d = base + 8'(i) * step;
      exp_a.push_back(8'(ref_ptr));
      exp_d.push_back(d);
      ref_mem[ref_ptr] = d;
      ref_ptr = (ref_ptr & 8'hF8) | ((ref_ptr + 1) & 7);
      wbyte(d, 1'b0, "R4 data ack");
    end
    bus_stop();
    tick(4);
    chk(exp_a.size() == 0, "R4/R5 strobes delivered", exp_a.size(), 0);
  endtask

  initial begin
    logic b;
    checks = 0; fails = 0; done = 0; quiet = 0; ref_ptr = 0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'h00;
      ref_mem[i] = 8'h00;
    end
    scl_m = 1'b1; sda_m = 1'b1; pins = 3'b101; rst_n = 1'b0;
    tick(5);
    chk(sda_pull == 1'b0 && mem_we == 1'b0, "R10 reset outputs", {sda_pull, mem_we}, 0);
    rst_n = 1'b1;
    tick(5);
    chk(sda_pull == 1'b0, "R10 idle released", int'(sda_pull), 0);

    wr_txn(8'h10, 2, 8'hA5, 8'h10);
    wr_txn(8'h06, 3, 8'h11, 8'h11);
    wr_txn(8'h43, 10, 8'h50, 8'h01);
    wr_txn(8'h08, 2, 8'hC1, 8'h01);

    bus_start();
    wbyte(dev(pins, 1'b0), 1'b0, "R1 address ack");
    wbyte(8'h06, 1'b0, "R3 pointer byte ack");
    ref_ptr = 8'h06;
    bus_start();
    wbyte(dev(pins, 1'b1), 1'b0, "R9 repeated start read ack");
    rbyte(1'b0, "R6 read byte 06h");
    rbyte(1'b0, "R7 read after ack 07h");
    rbyte(1'b1, "R7 read 08h then nack");
    quiet = 1;
    bit_r(b, "R7 released after nack");
    chk(b == 1'b1, "R7 SDA released after nack", int'(b), 1);
    bus_stop();
    quiet = 0;

    bus_start();
    wbyte(dev(pins, 1'b1), 1'b0, "R1 read address ack");
    rbyte(1'b1, "R8 current-address read");
    bus_stop();

    wr_txn(8'hFF, 1, 8'h77, 8'h00);
    bus_start();
    wbyte(dev(pins, 1'b0), 1'b0, "R1 address ack");
    wbyte(8'hFF, 1'b0, "R3 pointer byte ack");
    ref_ptr = 8'hFF;
    bus_start();
    wbyte(dev(pins, 1'b1), 1'b0, "R1 read address ack");
    rbyte(1'b0, "R7 read FFh");
    rbyte(1'b1, "R7 wrap to 00h");
    bus_stop();

    bus_start();
    quiet = 1;
    wbyte(dev(3'b100, 1'b0), 1'b1, "R2 wrong pins no ack");
    wbyte(8'h20, 1'b1, "R2 ignored pointer byte");
    wbyte(8'h99, 1'b1, "R2 ignored data byte");
    bus_stop();
    bus_start();
    wbyte({4'b1011, pins, 1'b0}, 1'b1, "R2 wrong prefix no ack");
    wbyte(8'h55, 1'b1, "R2 ignored byte");
    bus_stop();
    quiet = 0;
    bus_start();
    wbyte(dev(pins, 1'b0), 1'b0, "R2 answers after new start");
    wbyte(8'h20, 1'b0, "R3 pointer byte ack");
    ref_ptr = 8'h20;
    bus_start();
    wbyte(dev(pins, 1'b1), 1'b0, "R1 read address ack");
    rbyte(1'b1, "R2 ignored data not stored");
    bus_stop();

    bus_start();
    wbyte(dev(pins, 1'b0), 1'b0, "R1 address ack");
    wbyte(8'h30, 1'b0, "R3 pointer byte ack");
    ref_ptr = 8'h30;
    bit_w(1'b1); bit_w(1'b1); bit_w(1'b1);
    bus_stop();
    bus_start();
    wbyte(dev(pins, 1'b1), 1'b0, "R9 answers after aborted byte");
    rbyte(1'b1, "R9 aborted byte not stored");
    bus_stop();

    pins = 3'b010;
    tick(4);
    wr_txn(8'h50, 1, 8'hE7, 8'h00);
    bus_start();
    wbyte(dev(3'b101, 1'b0), 1'b1, "R1 old pins no longer match");
    bus_stop();

    tick(10);
    chk(exp_a.size() == 0, "R4 no pending strobes", exp_a.size(), 0);
    chk(sda_pull == 1'b0, "R10 released at end", int'(sda_pull), 0);
    finish_run();
  end

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    finish_run();
  end
endmodule